// File: doc/BRIEF.md
# Programmable Wait-State Memory Area Controller

This block runs bus cycles into a single memory area that may hold a slow external device or internal destinations. One 32-bit configuration word sets how many wait cycles each cycle spends in three ordered phases: a start phase, an access phase and a stop phase. The counts can differ between reads and writes. The same word can also mark the area read-only. It can also hand the access timing over to an external ready line.

A processor-side master raises `reqValid` with a direction and a target flag. The request is taken while `reqReady` is high. The controller then drives chip select and a read or write strobe. It ends the bus cycle with a one-cycle `done` pulse. The configuration word is written on a separate port. Each access samples the word at the moment the request is taken, so a write that arrives during an access takes effect from the next access. When the target changes from external to internal, the first internal access costs one extra access cycle.

Top module: `wait_area_ctrl`

## Requirements
- R1: After reset, `cfgRdata` reads 0xFF000034, `reqReady` is high, and `chipSel`, `rdStrobe`, `wrStrobe`, `done` and `roError` are low.
- R2: When layout bits [7:6] are anything other than 01, the layout is the short one. Bits [31:28] give the access wait count, bits [27:24] give the stop wait count, the start count is zero, and reads and writes share these counts.
- R3: When bits [7:6] = 01, the word holds six 4-bit counts. Bits [31:28], [27:24] and [23:20] give the start, access and stop counts for writes. Bits [19:16], [15:12] and [11:8] give the same three counts for reads.
- R4: After a request is taken, the controller spends S cycles in the start phase and A+P+1 cycles in the access phase. It then spends T cycles in the stop phase, followed by a single cycle with `done` high, and is ready again after that. P is the target-change penalty. `chipSel` is high through the start and access phases only. A phase whose count is zero takes no cycles.
- R5: `rdStrobe` is high in every access-phase cycle of a read and never during a write. `wrStrobe` is high in every access-phase cycle of a write that is allowed and never during a read.
- R6: When bit 4 is 1, a write runs with the normal timing but never raises `wrStrobe`. It also sets `roError`, which stays high until reset. Reads in a read-only area are unaffected.
- R7: An internal access whose previous access went to the external target gets P = 1; the state after reset counts as external. Every other access gets P = 0.
- R8: When bit 5 is 0, all programmed counts are ignored and the start and stop phases take no cycles. The access phase lasts at least P+1 cycles. It ends at the first cycle from that point on in which `extReady` is high.
- R9: A word written on the configuration port appears on `cfgRdata` one cycle later. It governs the next access that is taken, not the one already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write enable |
| cfgWdata | input | 32 | Configuration write value |
| cfgRdata | output | 32 | Current configuration word |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | Request is a write (1) or read (0) |
| reqInternal | input | 1 | Request targets an internal destination (1) or the external device (0) |
| reqReady | output | 1 | Controller idle; a valid request is taken this cycle |
| extReady | input | 1 | External ready, used when bit 5 is 0 |
| chipSel | output | 1 | Area chip select, active high |
| rdStrobe | output | 1 | Read strobe, active high |
| wrStrobe | output | 1 | Write strobe, active high |
| done | output | 1 | One-cycle completion pulse |
| roError | output | 1 | Sticky flag for a write that was blocked by the read-only bit |

## Verification
The bench builds the block with its default reset word, 0xFF000034. This starts the first accesses in the short layout, with 15-cycle access and stop waits and the read-only bit set, so the largest counts and the blocked write can be reached before any configuration write. The bench then reprograms the area with six distinct counts, with all counts at zero, with an unused layout code and with wait control off. It also rewrites the word in the middle of an access.

// File: rtl/wait_area_pkg.sv
package wait_area_pkg;
  localparam int CFG_W   = 32;
  localparam int FIELD_W = 4;
  localparam int CNT_W   = FIELD_W + 1;

  typedef struct packed {
    logic [FIELD_W-1:0] startW;
    logic [FIELD_W-1:0] accW;
    logic [FIELD_W-1:0] stopW;
    logic               waitCtl;
    logic               readOnly;
  } timing_t;

  // control -> datapath
  typedef struct packed {
    logic capture;
    logic ldStart;
    logic ldAccess;
    logic ldStop;
    logic dec;
  } ctlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic cntLast;
    logic startZero;
    logic stopZero;
    logic useCounts;
    logic isWrite;
    logic roBlock;
  } dpStatus_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_ACCESS, PH_STOP, PH_DONE
  } phase_e;
endpackage

// File: rtl/wait_area_cfg.sv
module wait_area_cfg
  import wait_area_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = 32'hFF00_0034
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  input  logic             selWrite,
  output timing_t          liveTiming
);
  localparam int NUM_FIELDS = 6;

  logic [CFG_W-1:0] cfgReg;
  logic [FIELD_W-1:0] fld [NUM_FIELDS];
  logic [1:0] layout;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cfgReg <= RESET_CFG;
    else if (cfgWe) cfgReg <= cfgWdata;
  end

  assign cfgRdata = cfgReg;
  assign layout   = cfgReg[7:6];

  // fld[0] is the topmost nibble
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    assign fld[g] = cfgReg[CFG_W-1-g*FIELD_W -: FIELD_W];
  end

  always_comb begin
    liveTiming          = '0;
    liveTiming.waitCtl  = cfgReg[5];
    liveTiming.readOnly = cfgReg[4];
    if (layout == 2'b01) begin
      if (selWrite) begin
        liveTiming.startW = fld[0];
        liveTiming.accW   = fld[1];
        liveTiming.stopW  = fld[2];
      end else begin
        liveTiming.startW = fld[3];
        liveTiming.accW   = fld[4];
        liveTiming.stopW  = fld[5];
      end
    end else begin
      liveTiming.accW  = fld[0];
      liveTiming.stopW = fld[1];
    end
    if (!cfgReg[5]) begin
      liveTiming.startW = '0;
      liveTiming.accW   = '0;
      liveTiming.stopW  = '0;
    end
  end

  // R9: the register only moves on a port write
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(cfgReg));
endmodule

// File: rtl/wait_area_dp.sv
module wait_area_dp
  import wait_area_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t strobe,
  input  timing_t    liveTiming,
  input  logic       reqWrite,
  input  logic       reqInternal,
  output dpStatus_t  status,
  output logic       roError
);
  timing_t          snapT, effT;
  logic             snapWrite, snapPen, lastInternal, effPen;
  logic [CNT_W-1:0] cnt, accLoad;

  assign effT    = strobe.capture ? liveTiming : snapT;
  assign effPen  = strobe.capture ? (reqInternal & ~lastInternal) : snapPen;
  assign accLoad = CNT_W'(effT.accW) + CNT_W'(effPen) + CNT_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      snapT        <= '0;
      snapWrite    <= 1'b0;
      snapPen      <= 1'b0;
      lastInternal <= 1'b0;
      roError      <= 1'b0;
    end else if (strobe.capture) begin
      snapT        <= liveTiming;
      snapWrite    <= reqWrite;
      snapPen      <= reqInternal & ~lastInternal;
      lastInternal <= reqInternal;
      if (reqWrite && liveTiming.readOnly) roError <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                cnt <= '0;
    else if (strobe.ldStart)  cnt <= CNT_W'(effT.startW);
    else if (strobe.ldAccess) cnt <= accLoad;
    else if (strobe.ldStop)   cnt <= CNT_W'(effT.stopW);
    else if (strobe.dec)      cnt <= cnt - CNT_W'(1);
  end

  assign status.cntLast   = (cnt == CNT_W'(1));
  assign status.startZero = (effT.startW == '0);
  assign status.stopZero  = (effT.stopW == '0);
  assign status.useCounts = effT.waitCtl;
  assign status.isWrite   = strobe.capture ? reqWrite : snapWrite;
  assign status.roBlock   = effT.readOnly;

  // R6: blocked-write flag is sticky
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    roError |=> roError);
  // R4: the counter is never told to count below one
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dec |-> (cnt > CNT_W'(1)));
endmodule

// File: rtl/wait_area_ctl.sv
module wait_area_ctl
  import wait_area_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       extReady,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe,
  output logic       reqReady,
  output logic       chipSel,
  output logic       rdStrobe,
  output logic       wrStrobe,
  output logic       done
);
  phase_e phase, phaseNxt;
  logic   accessEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNxt;
  end

  assign accessEnd = status.cntLast & (status.useCounts | extReady);

  always_comb begin
    phaseNxt = phase;
    strobe   = '0;
    unique case (phase)
      PH_IDLE: if (reqValid) begin
        strobe.capture = 1'b1;
        if (status.startZero) begin
          strobe.ldAccess = 1'b1;
          phaseNxt        = PH_ACCESS;
        end else begin
          strobe.ldStart = 1'b1;
          phaseNxt       = PH_START;
        end
      end
      PH_START: if (status.cntLast) begin
        strobe.ldAccess = 1'b1;
        phaseNxt        = PH_ACCESS;
      end else strobe.dec = 1'b1;
      PH_ACCESS: if (accessEnd) begin
        if (status.stopZero) phaseNxt = PH_DONE;
        else begin
          strobe.ldStop = 1'b1;
          phaseNxt      = PH_STOP;
        end
      end else if (!status.cntLast) strobe.dec = 1'b1;
      PH_STOP: if (status.cntLast) phaseNxt = PH_DONE;
               else strobe.dec = 1'b1;
      PH_DONE: phaseNxt = PH_IDLE;
      default: phaseNxt = PH_IDLE;
    endcase
  end

  assign reqReady = (phase == PH_IDLE);
  assign chipSel  = (phase == PH_START) || (phase == PH_ACCESS);
  assign rdStrobe = (phase == PH_ACCESS) && !status.isWrite;
  assign wrStrobe = (phase == PH_ACCESS) && status.isWrite && !status.roBlock;
  assign done     = (phase == PH_DONE);

  // R5: strobes only inside chip select, never both
  p_strobe_in_cs_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe || wrStrobe) |-> chipSel);
  p_rdwr_excl_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrobe && wrStrobe));
  // R4: done is a single pulse followed by idle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && reqReady));
  // R8: without external ready the access phase holds
  p_ext_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_ACCESS) && !status.useCounts && !extReady) |=> (phase == PH_ACCESS));
endmodule

// File: rtl/wait_area_ctrl.sv
module wait_area_ctrl
  import wait_area_pkg::*;
#(
  parameter logic [31:0] RESET_CFG = 32'hFF00_0034
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [31:0] cfgWdata,
  output logic [31:0] cfgRdata,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqInternal,
  output logic        reqReady,
  input  logic        extReady,
  output logic        chipSel,
  output logic        rdStrobe,
  output logic        wrStrobe,
  output logic        done,
  output logic        roError
);
  timing_t    liveTiming;
  ctlStrobe_t strobe;
  dpStatus_t  status;

  wait_area_cfg #(.RESET_CFG(RESET_CFG)) cfg_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .selWrite(reqWrite), .liveTiming(liveTiming));

  wait_area_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .liveTiming(liveTiming),
    .reqWrite(reqWrite), .reqInternal(reqInternal), .status(status),
    .roError(roError));

  wait_area_ctl ctl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .extReady(extReady),
    .status(status), .strobe(strobe), .reqReady(reqReady),
    .chipSel(chipSel), .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .done(done));
endmodule

// File: tb/wait_area_ctrl_tb_top.sv
module wait_area_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [31:0] cfgWdata = '0, cfgRdata;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqInternal = 1'b0, extReady = 1'b0;
  logic reqReady, chipSel, rdStrobe, wrStrobe, done, roError;

  always #(CLK_PERIOD/2) clk = ~clk;

  wait_area_ctrl dut_i (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqInternal(reqInternal),
    .reqReady(reqReady), .extReady(extReady), .chipSel(chipSel),
    .rdStrobe(rdStrobe), .wrStrobe(wrStrobe), .done(done), .roError(roError));

  typedef struct {
    int    lat;
    int    cs;
    int    rd;
    int    wr;
    string tag;
  } item_t;

  item_t       sbq[$];
  int          nChecks = 0, nFails = 0, doneCount = 0;
  logic [31:0] cfgModel = 32'hFF00_0034;
  logic        lastIntModel = 1'b0;
  logic        finished = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic item_t model(input logic wr, input logic intl, input int m, input string tag);
    item_t it;
    int s, a, t, p, acc;
    p = (intl && !lastIntModel) ? 1 : 0;
    if (cfgModel[7:6] == 2'b01) begin
      s = wr ? int'(cfgModel[31:28]) : int'(cfgModel[19:16]);
      a = wr ? int'(cfgModel[27:24]) : int'(cfgModel[15:12]);
      t = wr ? int'(cfgModel[23:20]) : int'(cfgModel[11:8]);
    end else begin
      s = 0; a = int'(cfgModel[31:28]); t = int'(cfgModel[27:24]);
    end
    if (!cfgModel[5]) begin s = 0; t = 0; acc = m; end
    else acc = a + p + 1;
    it.cs  = s + acc;
    it.lat = s + acc + t + 1;
    it.rd  = wr ? 0 : acc;
    it.wr  = (wr && !cfgModel[4]) ? acc : 0;
    it.tag = tag;
    return it;
  endfunction

  task automatic cfgWrite(input logic [31:0] v);
    @(negedge clk);
    cfgWe = 1'b1; cfgWdata = v;
    @(negedge clk);
    cfgWe = 1'b0;
    cfgModel = v;
  endtask

  // m: with wait control off, extReady is raised in access cycle m
  task automatic doAcc(input logic wr, input logic intl, input int m, input string tag);
    int seen;
    sbq.push_back(model(wr, intl, m, tag));
    lastIntModel = intl;
    seen = doneCount;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqInternal = intl;
    @(negedge clk);
    reqValid = 1'b0;
    if (m > 0) begin
      repeat (m - 1) @(negedge clk);
      extReady = 1'b1;
    end
    while (doneCount == seen) @(negedge clk);
    extReady = 1'b0;
  endtask

  // monitor: samples a quarter period after the falling edge
  logic  tracking = 1'b0;
  int    cyc = 0, csN = 0, rdN = 0, wrN = 0;
  item_t got;
  always @(negedge clk) begin
    #(CLK_PERIOD/4);
    if (tracking) begin
      cyc++;
      if (chipSel)  csN++;
      if (rdStrobe) rdN++;
      if (wrStrobe) wrN++;
      if (done) begin
        tracking = 1'b0;
        if (sbq.size() == 0) chk("R4", "unexpected done", 1, 0);
        else begin
          got = sbq.pop_front();
          chk(got.tag, "latency to done", cyc, got.lat);
          chk(got.tag, "chip select cycles", csN, got.cs);
          chk(got.tag, "read strobe cycles", rdN, got.rd);
          chk(got.tag, "write strobe cycles", wrN, got.wr);
        end
        doneCount++;
      end
    end
    if (rstN && reqValid && reqReady) begin
      tracking = 1'b1; cyc = 0; csN = 0; rdN = 0; wrN = 0;
    end
  end

  initial begin
    repeat (CLK_PERIOD * 4000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    // R1: reset state
    chk("R1", "cfgRdata", int'(cfgRdata == 32'hFF00_0034), 1);
    chk("R1", "reqReady", int'(reqReady), 1);
    chk("R1", "outputs low", int'({chipSel, rdStrobe, wrStrobe, done, roError}), 0);
    rstN = 1'b1;

    // R2: short layout at reset, acc 15 stop 15, read-only
    doAcc(1'b0, 1'b0, 0, "R2");
    chk("R6", "roError after read", int'(roError), 0);
    doAcc(1'b1, 1'b0, 0, "R6");        // blocked write
    #(CLK_PERIOD/4);
    chk("R6", "roError after blocked write", int'(roError), 1);

    // R3: six distinct counts
    cfgWrite(32'h1234_566E);
    #(CLK_PERIOD/4);
    chk("R9", "cfgRdata readback", int'(cfgRdata == 32'h1234_566E), 1);
    doAcc(1'b1, 1'b0, 0, "R3");
    doAcc(1'b0, 1'b0, 0, "R3");
    // R7: target change penalty
    doAcc(1'b0, 1'b1, 0, "R7");
    doAcc(1'b0, 1'b1, 0, "R7");
    doAcc(1'b1, 1'b0, 0, "R5");
    doAcc(1'b1, 1'b1, 0, "R7");
    chk("R6", "roError sticky", int'(roError), 1);

    // R2: unused layout code falls back to short layout
    cfgWrite(32'h5200_00A0);
    doAcc(1'b0, 1'b0, 0, "R2");
    doAcc(1'b1, 1'b0, 0, "R2");

    // R4: all counts zero
    cfgWrite(32'h0000_006E);
    doAcc(1'b0, 1'b0, 0, "R4");
    doAcc(1'b1, 1'b0, 0, "R4");

    // R8: wait control off, counts ignored
    cfgWrite(32'hFFFF_FF4E);
    doAcc(1'b0, 1'b1, 4, "R8");
    doAcc(1'b0, 1'b0, 4, "R8");
    doAcc(1'b1, 1'b0, 1, "R8");
    doAcc(1'b1, 1'b1, 2, "R8");

    // R9: mid-access write only affects the following access
    cfgWrite(32'h3303_306E);
    lastIntModel = lastIntModel;
    fork
      doAcc(1'b0, 1'b0, 0, "R9");
      begin
        repeat (3) @(negedge clk);
        cfgWe = 1'b1; cfgWdata = 32'h0000_006E;
        @(negedge clk);
        cfgWe = 1'b0;
      end
    join
    cfgModel = 32'h0000_006E;
    doAcc(1'b0, 1'b0, 0, "R9");

    repeat (3) @(negedge clk);
    chk("R4", "scoreboard drained", sbq.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule